// File: doc/BRIEF.md
# Vector Halfword Store Unit

This unit executes an indexed store that writes one 16-bit element of a 128-bit vector register to memory. An instruction word arrives on a valid/ready issue port and is decoded. The unit reads a base and an index value from two general-register read ports and adds them to form a 32-bit effective address. Address bits [3:1] select one of eight halfword lanes of the vector operand. The unit then sends one write to a 16-byte-wide memory port. The write has two adjacent byte enables set, with the most-significant byte of the lane at the lower address.

When the write is accepted, the unit does two more things in the same cycle. It tells an external reservation holder to drop a load-reservation in the same 16-byte granule, if one is active and tracking is on. It also advances the program counter by 4. An instruction word that does not match the expected pattern is reported on an `unhandled` output. Such a word causes no write and leaves the program counter unchanged.

Top module: `vec_half_store`

## Requirements
- R1: A word is accepted as this store when bits [31:26] (LSB = bit 0) equal 31 and bits [10:1] equal 167; bit 0 is not examined, so both 0x7C00014E and 0x7C00014F are stores. The vector register number is bits [25:21], the base register number is bits [20:16] and the index register number is bits [15:11].
- R2: A base register number of 0 makes the base operand the constant zero, whatever register 0 holds.
- R3: The effective address is (base + index) truncated to 32 bits. The memory request address is that value with bits [3:0] cleared.
- R4: The lane is bits [3:1] of the effective address. Vector byte j is `vr_data[127-8j -: 8]`, and memory byte offset k is `mem_wdata[8k +: 8]` with enable `mem_be[k]`. Offset 2*lane carries vector byte 2*lane, and offset 2*lane+1 carries vector byte 2*lane+1.
- R5: Exactly two byte enables are set, at offsets 2*lane and 2*lane+1. All other bytes of the 16-byte line are left unchanged.
- R6: Each accepted store makes exactly one write. `mem_req` stays high, with address, data and enables stable, until `mem_ack`.
- R7: `rsv_clear` is high in the cycle `mem_req && mem_ack` only if `rsv_track_en` and `rsv_valid` are both high and `rsv_addr[31:4]` equals the line address bits [31:4]. Otherwise it stays low.
- R8: On the clock edge that completes the write, `pc` increases by 4. `done` is high for the one following cycle. The PC changes at no other time.
- R9: A non-matching word that is accepted raises `unhandled` for exactly one cycle. It causes no memory request and no PC change.
- R10: After reset, `pc` equals RESET_PC, `issue_ready` is 1, and `mem_req`, `done`, `unhandled` and `rsv_clear` are 0.
- R11: `issue_ready` is low while a write is pending, and an issue offered then is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Unit can take an instruction |
| issue_insn | input | 32 | Instruction word |
| gpr_a_idx | output | 5 | Base register number |
| gpr_a_data | input | XLEN | Base register value |
| gpr_b_idx | output | 5 | Index register number |
| gpr_b_data | input | XLEN | Index register value |
| vr_idx | output | 5 | Vector register number |
| vr_data | input | 8*VBYTES | Vector register value, byte 0 in the top bits |
| mem_req | output | 1 | Write request |
| mem_addr | output | AW | Line-aligned write address |
| mem_wdata | output | 8*VBYTES | Write data, offset k in bits [8k+7:8k] |
| mem_be | output | VBYTES | Byte enables |
| mem_ack | input | 1 | Write accepted |
| rsv_track_en | input | 1 | Reservation tracking enabled |
| rsv_valid | input | 1 | A reservation is held |
| rsv_addr | input | AW | Reserved address |
| rsv_clear | output | 1 | Drop the reservation |
| pc | output | AW | Program counter |
| done | output | 1 | Store completed (one cycle) |
| unhandled | output | 1 | Offered word was not this store (one cycle) |

## Verification
The memory write being accepted and the reservation being cancelled happen in the same cycle. The PC step is also committed on that same clock edge. The bench sets up a held reservation in several ways: in the same granule as the store, in a neighbouring granule, with the valid flag off, and with tracking off. It varies the acknowledge latency from zero to three cycles. On each vector it watches for `rsv_clear` in the exact cycle that `mem_req` and `mem_ack` are both high, and compares the result with its own granule comparison. It then checks that the PC rose by exactly 4 and that exactly one write occurred.

// File: rtl/vhs_pkg.sv
package vhs_pkg;

    localparam logic [5:0] PRIMARY_OP  = 6'd31;
    localparam logic [9:0] EXTENDED_OP = 10'd167;
    localparam int         REG_NUM_W   = 5;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_WRITE = 1'b1
    } phase_e;

    typedef struct packed {
        logic                 hit;
        logic [REG_NUM_W-1:0] vsrc;
        logic [REG_NUM_W-1:0] base_reg;
        logic [REG_NUM_W-1:0] index_reg;
    } dec_t;

    function automatic logic word_matches(input logic [31:0] w);
        return (w[31:26] == PRIMARY_OP) && (w[10:1] == EXTENDED_OP);
    endfunction

endpackage

// File: rtl/vhs_decode.sv
module vhs_decode
    import vhs_pkg::*;
(
    input  logic [31:0] insn,
    output dec_t        dec
);
    logic unused_rc;
    assign unused_rc = insn[0];

    always_comb begin
        dec.hit       = word_matches(insn);
        dec.vsrc      = insn[25:21];
        dec.base_reg  = insn[20:16];
        dec.index_reg = insn[15:11];
    end
endmodule

// File: rtl/vhs_agen.sv
module vhs_agen #(
    parameter int XLEN   = 64,
    parameter int AW     = 32,
    parameter int VBYTES = 16,
    localparam int OFF_W  = $clog2(VBYTES),
    localparam int LANE_W = OFF_W - 1
) (
    input  logic              base_is_zero,
    input  logic [XLEN-1:0]   base,
    input  logic [XLEN-1:0]   index,
    output logic [AW-1:0]     line_addr,
    output logic [LANE_W-1:0] lane
);
    logic [AW-1:0] base_eff;
    logic [AW-1:0] ea;
    logic          unused_bits;

    assign base_eff    = base_is_zero ? '0 : base[AW-1:0];
    assign ea          = base_eff + index[AW-1:0];
    assign lane        = ea[OFF_W-1:1];
    assign line_addr   = {ea[AW-1:OFF_W], {OFF_W{1'b0}}};
    assign unused_bits = ^{base[XLEN-1:AW], index[XLEN-1:AW], ea[0]};
endmodule

// File: rtl/vhs_lane_pack.sv
module vhs_lane_pack #(
    parameter int VBYTES = 16,
    localparam int LANES  = VBYTES / 2,
    localparam int LANE_W = $clog2(LANES),
    localparam int VW     = 8 * VBYTES
) (
    input  logic [LANE_W-1:0] lane,
    input  logic [VW-1:0]     vec,
    output logic [VW-1:0]     wdata,
    output logic [VBYTES-1:0] be
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic       sel;
        logic [7:0] hi_byte;
        logic [7:0] lo_byte;
        assign sel     = (lane == LANE_W'(l));
        assign hi_byte = vec[VW-1-8*(2*l)   -: 8];
        assign lo_byte = vec[VW-1-8*(2*l+1) -: 8];
        assign wdata[8*(2*l)   +: 8] = sel ? hi_byte : 8'h00;
        assign wdata[8*(2*l+1) +: 8] = sel ? lo_byte : 8'h00;
        assign be[2*l]   = sel;
        assign be[2*l+1] = sel;
    end
endmodule

// File: rtl/vhs_resv_match.sv
module vhs_resv_match #(
    parameter int AW     = 32,
    parameter int VBYTES = 16,
    localparam int OFF_W = $clog2(VBYTES)
) (
    input  logic          fire,
    input  logic          track_en,
    input  logic          held,
    input  logic [AW-1:0] held_addr,
    input  logic [AW-1:0] line_addr,
    output logic          cancel
);
    logic same_granule;
    logic unused_low;

    assign same_granule = (held_addr[AW-1:OFF_W] == line_addr[AW-1:OFF_W]);
    assign cancel       = fire && track_en && held && same_granule;
    assign unused_low   = ^{held_addr[OFF_W-1:0], line_addr[OFF_W-1:0]};
endmodule

// File: rtl/vec_half_store.sv
module vec_half_store
    import vhs_pkg::*;
#(
    parameter int          XLEN     = 64,
    parameter int          AW       = 32,
    parameter int          VBYTES   = 16,
    parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  issue_valid,
    output logic                  issue_ready,
    input  logic [31:0]           issue_insn,
    output logic [4:0]            gpr_a_idx,
    input  logic [XLEN-1:0]       gpr_a_data,
    output logic [4:0]            gpr_b_idx,
    input  logic [XLEN-1:0]       gpr_b_data,
    output logic [4:0]            vr_idx,
    input  logic [8*VBYTES-1:0]   vr_data,
    output logic                  mem_req,
    output logic [AW-1:0]         mem_addr,
    output logic [8*VBYTES-1:0]   mem_wdata,
    output logic [VBYTES-1:0]     mem_be,
    input  logic                  mem_ack,
    input  logic                  rsv_track_en,
    input  logic                  rsv_valid,
    input  logic [AW-1:0]         rsv_addr,
    output logic                  rsv_clear,
    output logic [AW-1:0]         pc,
    output logic                  done,
    output logic                  unhandled
);
    localparam int OFF_W  = $clog2(VBYTES);
    localparam int LANE_W = OFF_W - 1;
    localparam int VW     = 8 * VBYTES;

    dec_t              dec;
    phase_e            phase_q;
    logic [AW-1:0]     line_w,  line_q;
    logic [LANE_W-1:0] lane_w;
    logic [VW-1:0]     wdata_w, wdata_q;
    logic [VBYTES-1:0] be_w,    be_q;
    logic [AW-1:0]     pc_q;
    logic              done_q, unhandled_q;
    logic              accept, fire;

    vhs_decode u_dec (.insn(issue_insn), .dec(dec));

    assign gpr_a_idx = dec.base_reg;
    assign gpr_b_idx = dec.index_reg;
    assign vr_idx    = dec.vsrc;

    vhs_agen #(.XLEN(XLEN), .AW(AW), .VBYTES(VBYTES)) u_agen (
        .base_is_zero (dec.base_reg == '0),
        .base         (gpr_a_data),
        .index        (gpr_b_data),
        .line_addr    (line_w),
        .lane         (lane_w)
    );

    vhs_lane_pack #(.VBYTES(VBYTES)) u_pack (
        .lane  (lane_w),
        .vec   (vr_data),
        .wdata (wdata_w),
        .be    (be_w)
    );

    assign issue_ready = (phase_q == PH_IDLE);
    assign accept      = issue_valid && issue_ready;
    assign mem_req     = (phase_q == PH_WRITE);
    assign fire        = mem_req && mem_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            pc_q        <= RESET_PC[AW-1:0];
            line_q      <= '0;
            wdata_q     <= '0;
            be_q        <= '0;
            done_q      <= 1'b0;
            unhandled_q <= 1'b0;
        end else begin
            done_q      <= 1'b0;
            unhandled_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        if (dec.hit) begin
                            phase_q <= PH_WRITE;
                            line_q  <= line_w;
                            wdata_q <= wdata_w;
                            be_q    <= be_w;
                        end else begin
                            unhandled_q <= 1'b1;
                        end
                    end
                end
                PH_WRITE: begin
                    if (mem_ack) begin
                        phase_q <= PH_IDLE;
                        pc_q    <= pc_q + AW'(4);
                        done_q  <= 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    vhs_resv_match #(.AW(AW), .VBYTES(VBYTES)) u_resv (
        .fire      (fire),
        .track_en  (rsv_track_en),
        .held      (rsv_valid),
        .held_addr (rsv_addr),
        .line_addr (line_q),
        .cancel    (rsv_clear)
    );

    assign mem_addr  = line_q;
    assign mem_wdata = wdata_q;
    assign mem_be    = be_q;
    assign pc        = pc_q;
    assign done      = done_q;
    assign unhandled = unhandled_q;

    p_two_bytes_r5: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> $countones(mem_be) == 2);

    p_hold_req_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_be) && $stable(mem_wdata)));

    p_cancel_on_write_r7: assert property (@(posedge clk) disable iff (rst)
        rsv_clear |-> (mem_req && mem_ack && rsv_valid && rsv_track_en));

    p_cancel_granule_r7: assert property (@(posedge clk) disable iff (rst)
        rsv_clear |-> (rsv_addr[AW-1:OFF_W] == mem_addr[AW-1:OFF_W]));

    p_pc_step_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (pc == $past(pc) + AW'(4)));

    p_done_follows_ack_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_req && mem_ack));

    p_unhandled_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        unhandled |-> (!mem_req && !done));
endmodule

// File: tb/test_vec_half_store.sv
`timescale 1ns/1ps
module test_vec_half_store;
    logic         clk = 1'b0;
    logic         rst;
    logic         issue_valid;
    logic         issue_ready;
    logic [31:0]  issue_insn;
    logic [4:0]   gpr_a_idx, gpr_b_idx, vr_idx;
    logic [63:0]  gpr_a_data, gpr_b_data;
    logic [127:0] vr_data;
    logic         mem_req, mem_ack;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [15:0]  mem_be;
    logic         rsv_track_en, rsv_valid, rsv_clear;
    logic [31:0]  rsv_addr;
    logic [31:0]  pc;
    logic         done, unhandled;

    localparam logic [31:0] START_PC = 32'h0000_1000;

    always #2 clk = ~clk;

    vec_half_store #(.RESET_PC(START_PC)) i_vec_half_store (
        .clk, .rst, .issue_valid, .issue_ready, .issue_insn,
        .gpr_a_idx, .gpr_a_data, .gpr_b_idx, .gpr_b_data,
        .vr_idx, .vr_data,
        .mem_req, .mem_addr, .mem_wdata, .mem_be, .mem_ack,
        .rsv_track_en, .rsv_valid, .rsv_addr, .rsv_clear,
        .pc, .done, .unhandled
    );

    // register file models
    logic [63:0] gpr [32];
    function automatic logic [7:0] vbyte(input logic [4:0] v, input int j);
        return 8'((int'(v) * 17 + j * 29 + 3) & 255);
    endfunction
    function automatic logic [127:0] vpat(input logic [4:0] v);
        logic [127:0] r;
        for (int j = 0; j < 16; j++) r[127-8*j -: 8] = vbyte(v, j);
        return r;
    endfunction
    assign gpr_a_data = gpr[gpr_a_idx];
    assign gpr_b_data = gpr[gpr_b_idx];
    assign vr_data    = vpat(vr_idx);

    // memory acknowledge model with programmable latency
    int         ack_dly;
    logic [1:0] wcnt;
    always @(posedge clk) begin
        if (rst)                      wcnt <= 2'd0;
        else if (mem_req && !mem_ack) wcnt <= wcnt + 2'd1;
        else                          wcnt <= 2'd0;
    end
    assign mem_ack = mem_req && (int'(wcnt) == ack_dly);

    int nchk = 0;
    int nfail = 0;

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [4:0]  vs;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic        rc;
        logic [63:0] base;
        logic [63:0] idx;
        logic [1:0]  dly;
        logic        ren;
        logic        rval;
        logic        rsame;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{5'd3,  5'd4,  5'd5,  1'b0, 64'h1000,                64'h6,          2'd0, 1'b0, 1'b0, 1'b0},
        '{5'd7,  5'd0,  5'd7,  1'b0, 64'h0,                   64'h2000_000F,  2'd1, 1'b0, 1'b0, 1'b0},
        '{5'd1,  5'd2,  5'd3,  1'b0, 64'h40,                  64'h0,          2'd2, 1'b1, 1'b1, 1'b1},
        '{5'd12, 5'd6,  5'd8,  1'b0, 64'h50,                  64'h1,          2'd0, 1'b1, 1'b1, 1'b0},
        '{5'd20, 5'd10, 5'd11, 1'b0, 64'hFFFF_FFFF_FFFF_FFF8, 64'h10,         2'd1, 1'b0, 1'b1, 1'b1},
        '{5'd5,  5'd12, 5'd13, 1'b0, 64'hA00,                 64'hBC,         2'd3, 1'b1, 1'b0, 1'b1},
        '{5'd9,  5'd14, 5'd15, 1'b1, 64'h30,                  64'hA,          2'd0, 1'b1, 1'b1, 1'b1},
        '{5'd2,  5'd9,  5'd9,  1'b0, 64'h103,                 64'h103,        2'd2, 1'b0, 1'b0, 1'b0},
        '{5'd30, 5'd16, 5'd17, 1'b0, 64'h7FFF_0000,           64'hFFF2,       2'd3, 1'b1, 1'b1, 1'b1},
        '{5'd31, 5'd18, 5'd19, 1'b0, 64'h1234_0000_1234_0000, 64'h5675,       2'd1, 1'b1, 1'b1, 1'b0}
    };

    // observations of one store
    int           r_writes;
    logic [31:0]  r_addr;
    logic [15:0]  r_be;
    logic [127:0] r_img;
    logic         r_clr, r_rdy_busy, r_done;
    logic [31:0]  exp_pc;

    function automatic logic [127:0] background();
        logic [127:0] b;
        for (int k = 0; k < 16; k++) b[8*k +: 8] = 8'hA0 + 8'(k);
        return b;
    endfunction

    task automatic run_store(input logic [31:0] insn, input int dly, input bit flood);
        r_writes = 0; r_clr = 1'b0; r_rdy_busy = 1'b0; r_done = 1'b0;
        r_addr = '0; r_be = '0; r_img = background();
        ack_dly = dly;
        @(negedge clk);
        issue_valid = 1'b1;
        issue_insn  = insn;
        @(negedge clk);
        if (!flood) issue_valid = 1'b0;
        else        issue_insn  = {6'd31, 5'd4, 5'd4, 5'd5, 10'd167, 1'b0};
        for (int c = 0; c < 20; c++) begin
            if (mem_req && issue_ready) r_rdy_busy = 1'b1;
            if (mem_req && mem_ack) begin
                r_writes++;
                r_addr = mem_addr;
                r_be   = mem_be;
                r_clr  = r_clr | rsv_clear;
                for (int k = 0; k < 16; k++)
                    if (mem_be[k]) r_img[8*k +: 8] = mem_wdata[8*k +: 8];
            end else if (rsv_clear) begin
                r_clr = 1'b1;
            end
            if (done) begin
                r_done = 1'b1;
                issue_valid = 1'b0;
                break;
            end
            @(negedge clk);
        end
        issue_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        rst = 1'b1; issue_valid = 1'b0; issue_insn = '0; ack_dly = 0;
        rsv_track_en = 1'b0; rsv_valid = 1'b0; rsv_addr = '0;
        for (int i = 0; i < 32; i++) gpr[i] = 64'h0;
        gpr[0] = 64'hFFFF_0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        chk("R10", "pc", pc, START_PC);
        chk("R10", "ready", issue_ready, 1'b1);
        chk("R10", "req/done/unh/clr", {mem_req, done, unhandled, rsv_clear}, 4'b0);
        exp_pc = START_PC;

        // vector table walk: R1..R8
        for (int v = 0; v < NV; v++) begin
            vec_t         t;
            logic [31:0]  ea, line;
            int           lane;
            logic [15:0]  ebe;
            logic [127:0] eimg;
            logic         eclr;
            string        areq;
            t = VECS[v];
            if (t.ra != 5'd0) gpr[t.ra] = t.base;
            gpr[t.rb] = t.idx;
            ea   = 32'(((t.ra == 5'd0) ? 64'h0 : t.base) + t.idx);
            line = {ea[31:4], 4'h0};
            lane = int'(ea[3:1]);
            ebe  = 16'h3 << (2 * lane);
            eimg = background();
            eimg[8*(2*lane) +: 8]   = vbyte(t.vs, 2*lane);
            eimg[8*(2*lane+1) +: 8] = vbyte(t.vs, 2*lane+1);
            rsv_track_en = t.ren;
            rsv_valid    = t.rval;
            rsv_addr     = t.rsame ? (line | 32'h6) : (line ^ 32'h10);
            eclr = t.ren && t.rval && t.rsame;
            areq = (t.ra == 5'd0) ? "R2" : "R3";

            run_store({6'd31, t.vs, t.ra, t.rb, 10'd167, t.rc}, int'(t.dly), 1'b0);
            exp_pc = exp_pc + 32'd4;
            if (r_clr) rsv_valid = 1'b0;

            chk("R1", "completed", r_done, 1'b1);
            chk("R6", "write count", r_writes, 1);
            chk(areq, "line address", r_addr, line);
            chk("R4", "byte enables", r_be, ebe);
            chk("R5", "line image", r_img, eimg);
            chk("R7", "reservation cancel", r_clr, eclr);
            chk("R8", "pc", pc, exp_pc);
            chk("R11", "ready while busy", r_rdy_busy, 1'b0);
        end

        // R9 unhandled words: wrong extended opcode, wrong primary opcode
        for (int u = 0; u < 2; u++) begin
            logic [31:0] w;
            bit          saw_req;
            w = (u == 0) ? 32'h7C00014C : 32'h7800014E;
            @(negedge clk);
            issue_valid = 1'b1; issue_insn = w;
            @(negedge clk);
            issue_valid = 1'b0;
            chk("R9", "unhandled raised", unhandled, 1'b1);
            saw_req = mem_req;
            @(negedge clk);
            chk("R9", "unhandled one cycle", unhandled, 1'b0);
            repeat (3) begin
                saw_req = saw_req | mem_req;
                @(negedge clk);
            end
            chk("R9", "no request", saw_req, 1'b0);
            chk("R9", "pc unchanged", pc, exp_pc);
        end

        // R11 issue offered while busy is ignored
        rsv_track_en = 1'b0; rsv_valid = 1'b0;
        gpr[4] = 64'h800; gpr[5] = 64'h4;
        run_store({6'd31, 5'd6, 5'd4, 5'd5, 10'd167, 1'b0}, 3, 1'b1);
        exp_pc = exp_pc + 32'd4;
        chk("R11", "ready while busy", r_rdy_busy, 1'b0);
        chk("R11", "single write", r_writes, 1);
        chk("R11", "pc", pc, exp_pc);
        repeat (4) @(negedge clk);
        chk("R11", "no extra request", mem_req, 1'b0);
        chk("R11", "pc after idle", pc, exp_pc);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule